// File: doc/BRIEF.md
# Two-Port Hardware Semaphore Flags

A small bank of ownership flags that two independent ports share to agree on who owns a software resource. Each port reaches the bank with its semaphore select low and its memory chip select high. The low address bits pick one flag. Writing 0 to a flag asks for it and writing 1 gives it up. A read then shows whether the port holds the flag. The data word is split into byte lanes. Each lane carries its own independent flag set and is written through bit 0 of the lane.

A request made while the other port owns the flag is kept as pending. When the owner releases the flag, the pending request is granted on the same clock edge. If both ports ask for a free flag in the same cycle, the left port wins and the right request stays pending. The port logic is synchronous: a write takes effect at the clock edge, and read data is registered, so it appears on the clock edge after the read cycle.

Top module: `sem_bank`

## Requirements
- R1: After reset every flag in every lane is free. A read of any flag from either port returns 32'hFFFFFFFF.
- R2: An access needs semaphore select low and chip select high. A write also needs write enable low. A read needs write enable high and output enable low. Read data appears at the clock edge after the read cycle. In every other cycle the read data bus is 0.
- R3: A cycle with both chip select and semaphore select low changes no flag state, and the read data bus stays 0 after it.
- R4: Writing 0 to a free flag grants it to the writer. The writer then reads 8'h00 in that lane and the other port reads 8'hFF. The two ports never both own one flag.
- R5: The address selects one of 8 flags. A write to one flag leaves the other flags unchanged.
- R6: Lane k (k = 0..3) is written from data bit 8*k. Lane k's read value is driven on bits 8*k+7..8*k, all eight bits equal to the inverse of "this port owns the flag".
- R7: Writing 1 to a held flag releases it. If the other port has a pending request, that port becomes the owner at the same clock edge.
- R8: Writing 0 to a flag that the other port owns leaves the request pending. The requester keeps reading 8'hFF in that lane.
- R9: When both ports write 0 to the same free flag and lane in one cycle, the left port gets it and the right request stays pending.
- R10: Writing 1 while a request is pending and not yet granted withdraws the request, so a later release by the owner leaves the flag free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| l_cs_n | input | 1 | Left memory chip select, active low (must be high for flag access) |
| l_sem_n | input | 1 | Left semaphore select, active low |
| l_we_n | input | 1 | Left write enable, active low |
| l_oe_n | input | 1 | Left output enable, active low |
| l_addr | input | 3 | Left flag index |
| l_wdata | input | 32 | Left write data (bits 0, 8, 16, 24 used) |
| l_rdata | output | 32 | Left registered read data |
| r_cs_n | input | 1 | Right memory chip select, active low |
| r_sem_n | input | 1 | Right semaphore select, active low |
| r_we_n | input | 1 | Right write enable, active low |
| r_oe_n | input | 1 | Right output enable, active low |
| r_addr | input | 3 | Right flag index |
| r_wdata | input | 32 | Right write data (bits 0, 8, 16, 24 used) |
| r_rdata | output | 32 | Right registered read data |

## Verification
Suppose an ownership bit or a pending-request bit is corrupted. The fault shows as a wrong lane byte on the next read of that flag, one clock after the read cycle. One example is a port reading 00 for a flag the other side holds. Another is a flag that stays at FF after its owner has released it to a waiting port. A lost pending bit only shows up when the owner releases the flag. So each hand-off test reads the flag from both ports right after the release write, and each cancel test does the same after the withdrawal.

// File: rtl/sem_bank.sv
module sem_bank #(
  parameter int LANES = 4,
  parameter int LANEW = 8,
  parameter int NFLAG = 8,
  localparam int AW = $clog2(NFLAG),
  localparam int DW = LANES * LANEW,
  localparam int NS = LANES * NFLAG
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          l_cs_n,
  input  logic          l_sem_n,
  input  logic          l_we_n,
  input  logic          l_oe_n,
  input  logic [AW-1:0] l_addr,
  input  logic [DW-1:0] l_wdata,
  output logic [DW-1:0] l_rdata,
  input  logic          r_cs_n,
  input  logic          r_sem_n,
  input  logic          r_we_n,
  input  logic          r_oe_n,
  input  logic [AW-1:0] r_addr,
  input  logic [DW-1:0] r_wdata,
  output logic [DW-1:0] r_rdata
);

  logic [NS-1:0] own_l, own_r, req_l, req_r;
  logic [NS-1:0] nown_l, nown_r, nreq_l, nreq_r;
  logic [DW-1:0] l_rval, r_rval;

  wire l_acc = l_cs_n & ~l_sem_n;
  wire r_acc = r_cs_n & ~r_sem_n;
  wire l_wr  = l_acc & ~l_we_n;
  wire r_wr  = r_acc & ~r_we_n;
  wire l_rd  = l_acc & l_we_n & ~l_oe_n;
  wire r_rd  = r_acc & r_we_n & ~r_oe_n;

  logic unused_wdata;
  assign unused_wdata = ^{l_wdata, r_wdata};

  always_comb begin
    nreq_l = req_l;
    nreq_r = req_r;
    for (int ln = 0; ln < LANES; ln++) begin
      if (l_wr) nreq_l[ln*NFLAG + int'(l_addr)] = ~l_wdata[ln*LANEW];
      if (r_wr) nreq_r[ln*NFLAG + int'(r_addr)] = ~r_wdata[ln*LANEW];
    end
    for (int i = 0; i < NS; i++) begin
      logic kl, kr;
      kl = own_l[i] & nreq_l[i];
      kr = own_r[i] & nreq_r[i];
      nown_l[i] = kl | (~kr & nreq_l[i]);
      nown_r[i] = kr | (~kl & ~nreq_l[i] & nreq_r[i]);
    end
  end

  always_comb begin
    for (int ln = 0; ln < LANES; ln++) begin
      l_rval[ln*LANEW +: LANEW] = {LANEW{~own_l[ln*NFLAG + int'(l_addr)]}};
      r_rval[ln*LANEW +: LANEW] = {LANEW{~own_r[ln*NFLAG + int'(r_addr)]}};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      own_l   <= '0;
      own_r   <= '0;
      req_l   <= '0;
      req_r   <= '0;
      l_rdata <= '0;
      r_rdata <= '0;
    end else begin
      own_l   <= nown_l;
      own_r   <= nown_r;
      req_l   <= nreq_l;
      req_r   <= nreq_r;
      l_rdata <= l_rd ? l_rval : '0;
      r_rdata <= r_rd ? r_rval : '0;
    end
  end

endmodule

// File: rtl/sem_bank_chk.sv
module sem_bank_chk #(
  parameter int LANES = 4,
  parameter int LANEW = 8,
  parameter int NFLAG = 8,
  localparam int AW = $clog2(NFLAG),
  localparam int DW = LANES * LANEW,
  localparam int NS = LANES * NFLAG
) (
  input logic          clk,
  input logic          rst_n,
  input logic          l_cs_n,
  input logic          l_sem_n,
  input logic          l_we_n,
  input logic          l_oe_n,
  input logic [AW-1:0] l_addr,
  input logic [DW-1:0] l_rdata,
  input logic          r_cs_n,
  input logic          r_sem_n,
  input logic          r_we_n,
  input logic          r_oe_n,
  input logic [AW-1:0] r_addr,
  input logic [DW-1:0] r_rdata,
  input logic [NS-1:0] own_l,
  input logic [NS-1:0] own_r,
  input logic [NS-1:0] req_l,
  input logic [NS-1:0] req_r
);

  wire lrd = l_cs_n && !l_sem_n && l_we_n && !l_oe_n;
  wire rrd = r_cs_n && !r_sem_n && r_we_n && !r_oe_n;
  wire l_bad = !l_cs_n && !l_sem_n;
  wire r_bad = !r_cs_n && !r_sem_n;
  wire l_nowr = !(l_cs_n && !l_sem_n && !l_we_n);
  wire r_nowr = !(r_cs_n && !r_sem_n && !r_we_n);

  a_r4_single_owner: assert property (@(posedge clk) disable iff (!rst_n)
    (own_l & own_r) == '0);

  a_r2_l_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !lrd |=> l_rdata == '0);

  a_r2_r_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !rrd |=> r_rdata == '0);

  a_r3_illegal_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (l_bad && r_bad) || (l_bad && r_nowr) || (r_bad && l_nowr)
    |=> $stable(own_l) && $stable(own_r) && $stable(req_l) && $stable(req_r));

  a_r7_no_grant_without_request: assert property (@(posedge clk) disable iff (!rst_n)
    ((own_l & ~req_l) == '0) && ((own_r & ~req_r) == '0));

  for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
    a_r6_l_replicated: assert property (@(posedge clk) disable iff (!rst_n)
      lrd |=> (l_rdata[ln*LANEW +: LANEW] == '0) || (&l_rdata[ln*LANEW +: LANEW]));
    a_r6_r_replicated: assert property (@(posedge clk) disable iff (!rst_n)
      rrd |=> (r_rdata[ln*LANEW +: LANEW] == '0) || (&r_rdata[ln*LANEW +: LANEW]));
  end

endmodule

bind sem_bank sem_bank_chk #(.LANES(LANES), .LANEW(LANEW), .NFLAG(NFLAG)) u_chk (.*);

// File: tb/sem_bank_tb.sv
`timescale 1ns/1ps
module sem_bank_tb;
  logic clk = 0, rst_n = 0;
  logic l_cs_n = 1, l_sem_n = 1, l_we_n = 1, l_oe_n = 1;
  logic r_cs_n = 1, r_sem_n = 1, r_we_n = 1, r_oe_n = 1;
  logic [2:0] l_addr = 0, r_addr = 0;
  logic [31:0] l_wdata = 0, r_wdata = 0;
  logic [31:0] l_rdata, r_rdata;
  int checks = 0, errors = 0;
  logic [31:0] v;

  always #2.5 clk = ~clk;

  sem_bank u_dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    l_cs_n = 1; l_sem_n = 1; l_we_n = 1; l_oe_n = 1;
    r_cs_n = 1; r_sem_n = 1; r_we_n = 1; r_oe_n = 1;
  endtask

  task automatic wr(input bit left, input bit right, input logic [2:0] la, input logic [31:0] ld,
                    input logic [2:0] ra, input logic [31:0] rd);
    @(negedge clk);
    if (left)  begin l_sem_n = 0; l_we_n = 0; l_addr = la; l_wdata = ld; end
    if (right) begin r_sem_n = 0; r_we_n = 0; r_addr = ra; r_wdata = rd; end
    @(negedge clk);
    idle();
  endtask

  task automatic rd(input bit left, input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    if (left) begin l_sem_n = 0; l_oe_n = 0; l_addr = a; end
    else      begin r_sem_n = 0; r_oe_n = 0; r_addr = a; end
    @(negedge clk);
    d = left ? l_rdata : r_rdata;
    idle();
  endtask

  task automatic t_reset();
    chk("R1 idle l_rdata after reset", l_rdata, 0);
    for (int f = 0; f < 8; f++) begin
      rd(1, f[2:0], v); chk("R1 left free", v, 32'hFFFFFFFF);
      rd(0, f[2:0], v); chk("R1 right free", v, 32'hFFFFFFFF);
    end
    @(negedge clk);
    chk("R2 rdata zero after read cycle", l_rdata, 0);
  endtask

  task automatic t_grant();
    wr(1, 0, 3'd2, 32'h0, 0, 0);
    rd(1, 3'd2, v); chk("R4 left owns flag2", v, 32'h0);
    rd(0, 3'd2, v); chk("R4 right sees flag2 taken", v, 32'hFFFFFFFF);
    rd(1, 3'd3, v); chk("R5 flag3 untouched", v, 32'hFFFFFFFF);
  endtask

  task automatic t_lanes();
    wr(0, 1, 0, 0, 3'd5, 32'h00010001);
    rd(0, 3'd5, v); chk("R6 right lanes 1,3 owned", v, 32'h00FF00FF);
    rd(1, 3'd5, v); chk("R6 left sees flag5 lanes", v, 32'hFFFFFFFF);
  endtask

  task automatic t_pending();
    wr(0, 1, 0, 0, 3'd2, 32'h0);
    rd(0, 3'd2, v); chk("R8 right pending reads ones", v, 32'hFFFFFFFF);
    rd(1, 3'd2, v); chk("R8 left still owns", v, 32'h0);
    wr(1, 0, 3'd2, 32'h01010101, 0, 0);
    rd(0, 3'd2, v); chk("R7 right granted on release", v, 32'h0);
    rd(1, 3'd2, v); chk("R7 left released", v, 32'hFFFFFFFF);
    wr(0, 1, 0, 0, 3'd2, 32'h01010101);
    wr(0, 1, 0, 0, 3'd5, 32'h01010101);
    rd(1, 3'd2, v); chk("R7 flag2 free after release", v, 32'hFFFFFFFF);
    rd(0, 3'd5, v); chk("R7 flag5 free after release", v, 32'hFFFFFFFF);
  endtask

  task automatic t_tie();
    wr(1, 1, 3'd7, 32'h0, 3'd7, 32'h0);
    rd(1, 3'd7, v); chk("R9 left wins tie", v, 32'h0);
    rd(0, 3'd7, v); chk("R9 right loses tie", v, 32'hFFFFFFFF);
    wr(1, 0, 3'd7, 32'h01010101, 0, 0);
    rd(0, 3'd7, v); chk("R9 right pending granted", v, 32'h0);
    wr(0, 1, 0, 0, 3'd7, 32'h01010101);
  endtask

  task automatic t_cancel();
    wr(1, 0, 3'd1, 32'h0, 0, 0);
    wr(0, 1, 0, 0, 3'd1, 32'h0);
    wr(0, 1, 0, 0, 3'd1, 32'h01010101);
    wr(1, 0, 3'd1, 32'h01010101, 0, 0);
    rd(0, 3'd1, v); chk("R10 withdrawn request not granted", v, 32'hFFFFFFFF);
    rd(1, 3'd1, v); chk("R10 flag1 free", v, 32'hFFFFFFFF);
  endtask

  task automatic t_illegal();
    @(negedge clk);
    l_cs_n = 0; l_sem_n = 0; l_we_n = 0; l_addr = 3'd4; l_wdata = 0;
    @(negedge clk);
    l_we_n = 1; l_oe_n = 0;
    @(negedge clk);
    chk("R3 illegal read gives zero", l_rdata, 0);
    idle();
    rd(1, 3'd4, v); chk("R3 illegal write ignored left", v, 32'hFFFFFFFF);
    rd(0, 3'd4, v); chk("R3 illegal write ignored right", v, 32'hFFFFFFFF);
  endtask

  task automatic t_oe();
    wr(1, 0, 3'd6, 32'h0, 0, 0);
    @(negedge clk);
    l_sem_n = 0; l_addr = 3'd6;
    @(negedge clk);
    chk("R2 no output without oe", l_rdata, 0);
    idle();
    rd(1, 3'd6, v); chk("R2 read with oe", v, 32'h0);
    wr(1, 0, 3'd6, 32'h01010101, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_grant();
    t_lanes();
    t_pending();
    t_tie();
    t_cancel();
    t_illegal();
    t_oe();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #100000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule